// File: doc/BRIEF.md
# In-System Flash Programming Controller

This block lets a CPU modify an on-chip flash array through a small register file. The CPU loads an address (high and low byte), a data byte and an operation code. It then sets the start bit in the control register. Four operations are available: byte program, page erase, chip erase and read protection. A small flop-based array stands in for the flash. Erased bytes read as FFh.

Every operation is gated by a key sequence. The data register must be written with 55h, then AAh, then 55h, on consecutive bus writes. The next write must put 04h into the enable register. Once the controller is enabled, it stays enabled until reset.

A started operation raises `busy_o` for a fixed, parameterised number of cycles, which models the CPU stall. The operation takes effect on the last of those cycles. Bus writes are dropped while busy is high.

Top module: `flash_isp_ctrl`

## Requirements
- R1: The writes 55h, AAh, 55h to the data register (F6h), followed by 04h to the enable register (BFh), enable the controller. Reading BFh then returns 04h; before that it returns 00h.
- R2: Any bus write that is not the expected next step of the key sequence returns the sequence to its start. Enabling then needs the full four writes again.
- R3: Setting bit 7 of the control register (F7h) while the controller is not enabled has no effect: `busy_o` stays low and the array is unchanged.
- R4: When the controller is enabled, a write to F7h with bit 7 set raises `busy_o` from the next cycle for exactly BUSY_CYC cycles. While busy, bit 7 of an F7h read returns 1.
- R5: Bus writes made while `busy_o` is high are ignored, including a write in the last busy cycle.
- R6: Mode 0 (register F3h, bits 1:0) is byte program. It stores the data register into the byte at {address-high, address-low}, truncated to FLASH_AW bits.
- R7: Mode 1 is page erase. It sets to FFh every byte whose address bits above bit 8 match the target. Address bit 8 and the low byte are ignored, and other pages are unchanged.
- R8: Mode 2 is chip erase. It sets every byte to FFh, except that bytes at or above SVC_BASE are kept when `svc_lock_i` is high.
- R9: Chip erase clears read protection.
- R10: Mode 3 is protect. After it, every flash read returns 00h while the stored contents are kept.
- R11: After reset, the controller is disabled, `busy_o` is low, the registers read 00h and all flash bytes read FFh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 8 | Register address for write and read |
| bus_wdata_i | input | 8 | Register write data |
| bus_rdata_o | output | 8 | Register read data for bus_addr_i |
| svc_lock_i | input | 1 | Keeps the service region on chip erase |
| fl_raddr_i | input | FLASH_AW | Flash read address |
| fl_rdata_o | output | 8 | Flash read data |
| busy_o | output | 1 | Operation in progress |

## Verification
Two things can fall in the same cycle: the commit of an operation into the array, and a bus write that tries to change the registers feeding that commit. The bench provokes this by writing the address-high register exactly in the last busy cycle, which is the edge where the byte program lands. It then judges both effects. The stored byte must carry the old address, and the register read back must still hold its old value once busy has dropped.

// File: rtl/isp_pkg.sv
package isp_pkg;
  localparam logic [7:0] REG_MODE = 8'hF3;
  localparam logic [7:0] REG_AHI  = 8'hF4;
  localparam logic [7:0] REG_ALO  = 8'hF5;
  localparam logic [7:0] REG_DATA = 8'hF6;
  localparam logic [7:0] REG_CTRL = 8'hF7;
  localparam logic [7:0] REG_EN   = 8'hBF;
  localparam logic [7:0] KEY_A    = 8'h55;
  localparam logic [7:0] KEY_B    = 8'hAA;
  localparam logic [7:0] EN_KEY   = 8'h04;

  typedef enum logic [1:0] {OP_PROG = 2'd0, OP_PAGE = 2'd1, OP_CHIP = 2'd2, OP_PROT = 2'd3} isp_op_e;
  typedef enum logic [2:0] {US_IDLE, US_K1, US_K2, US_K3, US_ON} unlock_st_e;
endpackage

// File: rtl/isp_unlock.sv
module isp_unlock
  import isp_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  logic       hold_i,
  input  logic [7:0] addr_i,
  input  logic [7:0] wdata_i,
  output logic       en_o
);
  unlock_st_e st_q, st_d;
  logic       wr;

  assign wr = we_i && !hold_i;

  always_comb begin
    st_d = st_q;
    if (wr) begin
      unique case (st_q)
        US_IDLE: st_d = (addr_i == REG_DATA && wdata_i == KEY_A)  ? US_K1 : US_IDLE;
        US_K1:   st_d = (addr_i == REG_DATA && wdata_i == KEY_B)  ? US_K2 : US_IDLE;
        US_K2:   st_d = (addr_i == REG_DATA && wdata_i == KEY_A)  ? US_K3 : US_IDLE;
        US_K3:   st_d = (addr_i == REG_EN   && wdata_i == EN_KEY) ? US_ON : US_IDLE;
        default: st_d = US_ON;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) st_q <= US_IDLE;
    else         st_q <= st_d;

  assign en_o = (st_q == US_ON);

  a_r1_enable_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_o |=> en_o);
  a_r2_rise_on_en_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(en_o) |-> $past(we_i && addr_i == REG_EN));
endmodule

// File: rtl/isp_seq.sv
module isp_seq #(
  parameter int BUSY_CYC = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_req_i,
  input  logic en_i,
  output logic busy_o,
  output logic commit_o
);
  localparam int CNT_W = $clog2(BUSY_CYC + 1);

  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (!busy_q) begin
      if (start_req_i && en_i) begin
        busy_q <= 1'b1;
        cnt_q  <= CNT_W'(BUSY_CYC - 1);
      end
    end else if (cnt_q == '0) begin
      busy_q <= 1'b0;
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end

  assign busy_o   = busy_q;
  assign commit_o = busy_q && (cnt_q == '0);

  a_r4_busy_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && cnt_q != '0 |=> busy_q);
  a_r4_commit_ends_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |=> !busy_q);
  a_r3_no_start_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i && !busy_q |=> !busy_q);
endmodule

// File: rtl/isp_array.sv
module isp_array
  import isp_pkg::*;
#(
  parameter int FLASH_AW  = 11,
  parameter int PAGE_BITS = 9,
  parameter int SVC_BASE  = 1536
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                commit_i,
  input  isp_op_e             op_i,
  input  logic [FLASH_AW-1:0] addr_i,
  input  logic [7:0]          data_i,
  input  logic                lock_i,
  input  logic [FLASH_AW-1:0] raddr_i,
  output logic [7:0]          rdata_o
);
  localparam int DEPTH = 1 << FLASH_AW;

  logic [7:0] mem [DEPTH];
  logic       prot_q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_byte
    localparam logic [FLASH_AW-1:0] MY_ADDR = FLASH_AW'(g);
    localparam bit IN_SVC = (g >= SVC_BASE);
    logic prog_hit, erase_hit;
    assign prog_hit  = (op_i == OP_PROG) && (addr_i == MY_ADDR);
    assign erase_hit = ((op_i == OP_PAGE) &&
                        (addr_i[FLASH_AW-1:PAGE_BITS] == MY_ADDR[FLASH_AW-1:PAGE_BITS])) ||
                       ((op_i == OP_CHIP) && !(IN_SVC && lock_i));
    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni)                     mem[g] <= 8'hFF;
      else if (commit_i && prog_hit)   mem[g] <= data_i;
      else if (commit_i && erase_hit)  mem[g] <= 8'hFF;
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)                             prot_q <= 1'b0;
    else if (commit_i && op_i == OP_CHIP)    prot_q <= 1'b0;
    else if (commit_i && op_i == OP_PROT)    prot_q <= 1'b1;

  assign rdata_o = prot_q ? 8'h00 : mem[raddr_i];

  a_r9_chip_unprotects: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i && op_i == OP_CHIP |=> !prot_q);
  a_r10_protect_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i && op_i == OP_PROT |=> prot_q);
  a_r6_prog_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i && op_i == OP_PROG |=> mem[$past(addr_i)] == $past(data_i));
endmodule

// File: rtl/flash_isp_ctrl.sv
module flash_isp_ctrl
  import isp_pkg::*;
#(
  parameter int FLASH_AW  = 11,
  parameter int PAGE_BITS = 9,
  parameter int SVC_BASE  = 1536,
  parameter int BUSY_CYC  = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                bus_we_i,
  input  logic [7:0]          bus_addr_i,
  input  logic [7:0]          bus_wdata_i,
  output logic [7:0]          bus_rdata_o,
  input  logic                svc_lock_i,
  input  logic [FLASH_AW-1:0] fl_raddr_i,
  output logic [7:0]          fl_rdata_o,
  output logic                busy_o
);
  logic       en, busy, commit, wr, start_req;
  logic [1:0] mode_q;
  logic [7:0] ahi_q, alo_q, dat_q;

  assign wr        = bus_we_i && !busy;
  assign start_req = wr && bus_addr_i == REG_CTRL && bus_wdata_i[7];

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      mode_q <= '0;
      ahi_q  <= '0;
      alo_q  <= '0;
      dat_q  <= '0;
    end else if (wr) begin
      unique case (bus_addr_i)
        REG_MODE: mode_q <= bus_wdata_i[1:0];
        REG_AHI:  ahi_q  <= bus_wdata_i;
        REG_ALO:  alo_q  <= bus_wdata_i;
        REG_DATA: dat_q  <= bus_wdata_i;
        default: ;
      endcase
    end

  always_comb begin
    unique case (bus_addr_i)
      REG_MODE: bus_rdata_o = {6'b0, mode_q};
      REG_AHI:  bus_rdata_o = ahi_q;
      REG_ALO:  bus_rdata_o = alo_q;
      REG_DATA: bus_rdata_o = dat_q;
      REG_CTRL: bus_rdata_o = {busy, 7'b0};
      REG_EN:   bus_rdata_o = en ? EN_KEY : 8'h00;
      default:  bus_rdata_o = 8'h00;
    endcase
  end

  isp_unlock u_unlock (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (bus_we_i),
    .hold_i  (busy),
    .addr_i  (bus_addr_i),
    .wdata_i (bus_wdata_i),
    .en_o    (en)
  );

  isp_seq #(.BUSY_CYC(BUSY_CYC)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_req_i (start_req),
    .en_i        (en),
    .busy_o      (busy),
    .commit_o    (commit)
  );

  isp_array #(.FLASH_AW(FLASH_AW), .PAGE_BITS(PAGE_BITS), .SVC_BASE(SVC_BASE)) u_array (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .commit_i (commit),
    .op_i     (isp_op_e'(mode_q)),
    .addr_i   ({ahi_q[FLASH_AW-9:0], alo_q}),
    .data_i   (dat_q),
    .lock_i   (svc_lock_i),
    .raddr_i  (fl_raddr_i),
    .rdata_o  (fl_rdata_o)
  );

  assign busy_o = busy;

  a_r5_regs_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy && $past(busy) |-> $stable({mode_q, ahi_q, alo_q, dat_q}));
  a_r3_busy_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> $past(en));
endmodule

// File: tb/tb_flash_isp_ctrl.sv
module tb_flash_isp_ctrl;
  localparam int AW = 11;
  localparam int BC = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          we = 1'b0;
  logic [7:0]    addr = '0, wdata = '0;
  logic [7:0]    rdata, fdata;
  logic          lock = 1'b0;
  logic [AW-1:0] raddr = '0;
  logic          busy;
  int            checks = 0, failures = 0;

  always #10 clk = ~clk;

  flash_isp_ctrl #(.FLASH_AW(AW), .PAGE_BITS(9), .SVC_BASE(1536), .BUSY_CYC(BC)) dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_we_i(we), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .svc_lock_i(lock), .fl_raddr_i(raddr), .fl_rdata_o(fdata),
    .busy_o(busy));

  // {reg addr, write data, expected enable readback after write}
  localparam logic [23:0] SEQ_TBL [12] = '{
    24'hF655_00, 24'hF6AA_00, 24'hF6AA_00, 24'hF655_00, 24'hF6AA_00, 24'hF655_00,
    24'hF400_00, 24'hBF04_00, 24'hF655_00, 24'hF6AA_00, 24'hF655_00, 24'hBF04_04};

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [7:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd_reg(input logic [7:0] a, output logic [7:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic rd_fl(input logic [AW-1:0] a, output logic [7:0] d);
    raddr = a; #1; d = fdata;
  endtask

  task automatic run_op(input logic [1:0] m, input logic [7:0] hi, input logic [7:0] lo,
                        input logic [7:0] d);
    int n;
    bus_wr(8'hF3, {6'b0, m});
    bus_wr(8'hF4, hi);
    bus_wr(8'hF5, lo);
    bus_wr(8'hF6, d);
    bus_wr(8'hF7, 8'h80);
    n = 0;
    while (busy && n < 100) begin n++; @(negedge clk); end
    chk("R4 busy length", 8'(n), 8'(BC));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk("R11 busy", {7'b0, busy}, 8'h00);
    rd_reg(8'hBF, v); chk("R11 enable", v, 8'h00);
    rd_reg(8'hF4, v); chk("R11 addr hi", v, 8'h00);
    rd_fl(11'h000, v); chk("R11 flash", v, 8'hFF);
    rd_fl(11'h7FF, v); chk("R11 flash top", v, 8'hFF);

    // R3 start while disabled
    bus_wr(8'hF3, 8'h00); bus_wr(8'hF4, 8'h01); bus_wr(8'hF5, 8'h23);
    bus_wr(8'hF6, 8'h5A); bus_wr(8'hF7, 8'h80);
    chk("R3 busy stays low", {7'b0, busy}, 8'h00);
    repeat (BC + 2) @(negedge clk);
    rd_fl(11'h123, v); chk("R3 array unchanged", v, 8'hFF);

    // R1/R2 key sequence table
    for (int i = 0; i < 12; i++) begin
      bus_wr(SEQ_TBL[i][23:16], SEQ_TBL[i][15:8]);
      rd_reg(8'hBF, v);
      chk(i == 11 ? "R1 enable after sequence" : "R2 sequence restart", v, SEQ_TBL[i][7:0]);
    end

    // R4/R5/R6: program 0x123 with a write in the last busy cycle
    bus_wr(8'hF3, 8'h00); bus_wr(8'hF4, 8'h01); bus_wr(8'hF5, 8'h23);
    bus_wr(8'hF6, 8'h5A); bus_wr(8'hF7, 8'h80);
    chk("R4 busy rises", {7'b0, busy}, 8'h01);
    rd_reg(8'hF7, v); chk("R4 ctrl readback", v, 8'h80);
    repeat (BC - 1) @(negedge clk);
    chk("R4 busy in last cycle", {7'b0, busy}, 8'h01);
    bus_wr(8'hF4, 8'h77);
    chk("R4 busy falls", {7'b0, busy}, 8'h00);
    rd_reg(8'hF4, v); chk("R5 write in busy dropped", v, 8'h01);
    rd_fl(11'h123, v); chk("R6 program", v, 8'h5A);

    run_op(2'd0, 8'h08, 8'h10, 8'h66);
    rd_fl(11'h010, v); chk("R6 address truncation", v, 8'h66);
    run_op(2'd0, 8'h01, 8'hFF, 8'h11);
    run_op(2'd0, 8'h02, 8'h00, 8'h22);
    run_op(2'd0, 8'h03, 8'hFF, 8'h55);
    run_op(2'd0, 8'h07, 8'hFF, 8'h44);
    rd_fl(11'h1FF, v); chk("R6 program 1FF", v, 8'h11);

    // R7 page erase; bit 8 and low byte of the target ignored
    run_op(2'd1, 8'h01, 8'h80, 8'h00);
    rd_fl(11'h123, v); chk("R7 page erased 123", v, 8'hFF);
    rd_fl(11'h010, v); chk("R7 page erased 010", v, 8'hFF);
    rd_fl(11'h1FF, v); chk("R7 page erased 1FF", v, 8'hFF);
    rd_fl(11'h200, v); chk("R7 next page kept", v, 8'h22);
    rd_fl(11'h3FF, v); chk("R7 next page end kept", v, 8'h55);

    // R10 protect
    run_op(2'd3, 8'h00, 8'h00, 8'h00);
    rd_fl(11'h200, v); chk("R10 protected read", v, 8'h00);
    rd_fl(11'h7FF, v); chk("R10 protected read top", v, 8'h00);

    // R8/R9 chip erase with lock
    lock = 1'b1;
    run_op(2'd2, 8'h00, 8'h00, 8'h00);
    rd_fl(11'h7FF, v); chk("R9 unprotected, R8 service kept", v, 8'h44);
    rd_fl(11'h200, v); chk("R8 chip erased 200", v, 8'hFF);
    rd_fl(11'h3FF, v); chk("R8 chip erased 3FF", v, 8'hFF);

    // R8 chip erase without lock
    lock = 1'b0;
    run_op(2'd2, 8'h00, 8'h00, 8'h00);
    rd_fl(11'h7FF, v); chk("R8 service erased unlocked", v, 8'hFF);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule